// File: doc/BRIEF.md
# Compound Branch Condition Evaluator

This block decides whether a conditional jump is taken and produces the program counter for the next fetch. The decision combines two tests. The first compares two register operands. The second reads one of four status flags. A combining rule then merges the two results. The taken target is either the word that follows the branch instruction or that word added to the current PC.

The surrounding pipeline supplies all operands as inputs: the two operand values and their register indices, the flag vector, the six condition bits of the instruction, the low opcode bit, the PC that addresses the target word, and the target word itself. A one-cycle start strobe launches an evaluation. The decision, the next PC and a valid pulse appear on registered outputs on the following cycle and stay there until the next strobe.

Top module: `branch_cond_unit`

## Requirements
- R1: Condition bits [1:0] select the register test: 0 means equal, 1 means not equal, 2 means A less than B, and 3 means A less than or equal to B. Both ordered tests compare the operands as unsigned values.
- R2: When both register indices are equal and condition bits [1:0] are 0, the register test is true whatever the operand values are.
- R3: Condition bits [3:2] select one flag from `flags_in`, whose bit 0 is overflow, bit 1 zero, bit 2 sign and bit 3 parity. The code value selects the bit with the same index.
- R4: Condition bits [5:4] choose how the register test C and the flag F are merged: 0 gives C, 1 gives C or F, 2 gives C and not F, and 3 gives C or not F.
- R5: When the branch is taken and `rel_in` is 0, the next PC equals `target_in`.
- R6: When the branch is taken and `rel_in` is 1, the next PC equals `target_in + pc_in`, truncated to the data width.
- R7: When the branch is not taken, the next PC equals `pc_in + 1`, truncated to the data width.
- R8: `valid_out` is high for exactly the cycle after a cycle in which `start_in` is high. `taken_out` and `next_pc_out` change only on those strobes and otherwise keep their values.
- R9: While reset is asserted, and until the first strobe after it, `valid_out` and `taken_out` are 0 and `next_pc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_in | input | 1 | Evaluation strobe |
| opa_in | input | DATA_W | First register operand |
| opb_in | input | DATA_W | Second register operand |
| idxa_in | input | IDX_W | Index of the first operand register |
| idxb_in | input | IDX_W | Index of the second operand register |
| flags_in | input | 4 | Status flags {parity, sign, zero, overflow} |
| cond_in | input | 6 | Condition bits: mix rule, flag select, compare select |
| rel_in | input | 1 | 1 selects a PC-relative target |
| pc_in | input | DATA_W | PC that addresses the target word |
| target_in | input | DATA_W | Target word that follows the instruction |
| valid_out | output | 1 | Result valid, one cycle after the strobe |
| taken_out | output | 1 | Branch taken |
| next_pc_out | output | DATA_W | PC for the next fetch |

## Verification
Every internal decision is registered on the output one cycle after its strobe, so any wrong internal value shows up at the ports on that cycle. A bad compare, flag select or mix decode flips `taken_out`. This also moves `next_pc_out` between the target-based address and `pc_in + 1`. A wrong adder input or a dropped carry shows up as a wrong `next_pc_out` at the same sample. A register that updates without a strobe, or misses one, breaks either the hold of the outputs or the single-cycle `valid_out` pulse on the cycle right after.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_LT = 2'd2,
        CMP_LE = 2'd3
    } cmp_sel_e;

    typedef enum logic [1:0] {
        FLG_OVF  = 2'd0,
        FLG_ZERO = 2'd1,
        FLG_SIGN = 2'd2,
        FLG_PAR  = 2'd3
    } flag_sel_e;

    typedef enum logic [1:0] {
        MIX_CMP_ONLY = 2'd0,
        MIX_OR_FLAG  = 2'd1,
        MIX_AND_NFLG = 2'd2,
        MIX_OR_NFLG  = 2'd3
    } mix_sel_e;

    localparam int NUM_FLAGS = 4;
    localparam int COND_W    = 6;

endpackage

// File: rtl/branch_cmp.sv
module branch_cmp
    import branch_cond_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IDX_W-1:0]  idxa_i,
    input  logic [IDX_W-1:0]  idxb_i,
    input  cmp_sel_e          sel_i,
    output logic              hit_o
);
    logic same_reg;
    logic eq, lt;

    assign same_reg = (idxa_i == idxb_i);
    assign eq       = (opa_i == opb_i);
    assign lt       = (opa_i < opb_i);

    always_comb begin
        unique case (sel_i)
            CMP_EQ:  hit_o = same_reg | eq;
            CMP_NE:  hit_o = ~eq;
            CMP_LT:  hit_o = lt;
            CMP_LE:  hit_o = lt | eq;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_flagmix.sv
module branch_flagmix
    import branch_cond_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  flag_sel_e            fsel_i,
    input  mix_sel_e             mix_i,
    input  logic                 cmp_i,
    output logic                 take_o
);
    logic flag;
    logic [NUM_FLAGS-1:0] onehot;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_pick
        assign onehot[g] = (fsel_i == flag_sel_e'(g)) & flags_i[g];
    end
    assign flag = |onehot;

    always_comb begin
        unique case (mix_i)
            MIX_CMP_ONLY: take_o = cmp_i;
            MIX_OR_FLAG:  take_o = cmp_i | flag;
            MIX_AND_NFLG: take_o = cmp_i & ~flag;
            MIX_OR_NFLG:  take_o = cmp_i | ~flag;
            default:      take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] target_i,
    input  logic              rel_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] npc_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] taken_pc;

    assign addend   = rel_i ? pc_i : '0;
    assign taken_pc = target_i + addend;
    assign npc_o    = take_i ? taken_pc : (pc_i + ONE);
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import branch_cond_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_in,
    input  logic [DATA_W-1:0] opa_in,
    input  logic [DATA_W-1:0] opb_in,
    input  logic [IDX_W-1:0]  idxa_in,
    input  logic [IDX_W-1:0]  idxb_in,
    input  logic [3:0]        flags_in,
    input  logic [5:0]        cond_in,
    input  logic              rel_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0] target_in,
    output logic              valid_out,
    output logic              taken_out,
    output logic [DATA_W-1:0] next_pc_out
);
    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [DATA_W-1:0] npc;
    } state_t;

    state_t st_d, st_q;

    logic              cmp_hit;
    logic              take;
    logic [DATA_W-1:0] npc;

    branch_cmp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
        .opa_i  (opa_in),
        .opb_i  (opb_in),
        .idxa_i (idxa_in),
        .idxb_i (idxb_in),
        .sel_i  (cmp_sel_e'(cond_in[1:0])),
        .hit_o  (cmp_hit)
    );

    branch_flagmix u_mix (
        .flags_i (flags_in),
        .fsel_i  (flag_sel_e'(cond_in[3:2])),
        .mix_i   (mix_sel_e'(cond_in[5:4])),
        .cmp_i   (cmp_hit),
        .take_o  (take)
    );

    branch_target #(.DATA_W(DATA_W)) u_tgt (
        .pc_i     (pc_in),
        .target_i (target_in),
        .rel_i    (rel_in),
        .take_i   (take),
        .npc_o    (npc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_in;
        if (start_in) begin
            st_d.taken = take;
            st_d.npc   = npc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out   = st_q.valid;
    assign taken_out   = st_q.taken;
    assign next_pc_out = st_q.npc;

    // R8: strobe yields a valid pulse the next cycle, and only then
    assert_valid_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_in |=> valid_out);
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_in |=> !valid_out);
    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_in |=> ($stable(taken_out) && $stable(next_pc_out)));
    // R7: fall-through address
    assert_fallthrough_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_in && !take) |=> (next_pc_out == $past(pc_in) + DATA_W'(1)));
    // R5: absolute target
    assert_abs_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_in && take && !rel_in) |=> (next_pc_out == $past(target_in)));
    // R2: same register equality always taken when used alone
    assert_same_reg_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_in && idxa_in == idxb_in && cond_in == 6'd0) |=> taken_out);
endmodule

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
    localparam int DW = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_in = 1'b0;
    logic [DW-1:0] opa_in = '0, opb_in = '0, pc_in = '0, target_in = '0;
    logic [IW-1:0] idxa_in = '0, idxb_in = '0;
    logic [3:0]    flags_in = '0;
    logic [5:0]    cond_in = '0;
    logic          rel_in = 1'b0;
    logic          valid_out, taken_out;
    logic [DW-1:0] next_pc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    branch_cond_unit #(.DATA_W(DW), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .start_in(start_in),
        .opa_in(opa_in), .opb_in(opb_in), .idxa_in(idxa_in), .idxb_in(idxb_in),
        .flags_in(flags_in), .cond_in(cond_in), .rel_in(rel_in),
        .pc_in(pc_in), .target_in(target_in),
        .valid_out(valid_out), .taken_out(taken_out), .next_pc_out(next_pc_out)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                    input bit same, input logic [5:0] c, input logic [3:0] f);
        bit cm, fl;
        case (c[1:0])
            2'd0: cm = same || (a == b);
            2'd1: cm = (a != b);
            2'd2: cm = (a < b);
            default: cm = (a <= b);
        endcase
        fl = f[c[3:2]];
        case (c[5:4])
            2'd0: return cm;
            2'd1: return cm || fl;
            2'd2: return cm && !fl;
            default: return cm || !fl;
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] av [5];
        logic [DW-1:0] bv [5];
        bit            sv [5];
        av[0] = 32'd5;          bv[0] = 32'd5;          sv[0] = 1'b0;
        av[1] = 32'd5;          bv[1] = 32'd9;          sv[1] = 1'b0;
        av[2] = 32'd9;          bv[2] = 32'd5;          sv[2] = 1'b0;
        av[3] = 32'hFFFF_FFFF;  bv[3] = 32'd1;          sv[3] = 1'b0;
        av[4] = 32'd3;          bv[4] = 32'd7;          sv[4] = 1'b1;

        // R9: reset state
        start_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 valid", DW'(valid_out), '0);
        check("R9 taken", DW'(taken_out), '0);
        check("R9 next_pc", next_pc_out, '0);
        start_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", DW'(valid_out), '0);

        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 64; c++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int r = 0; r < 2; r++) begin
                        bit            et;
                        logic [DW-1:0] epc;
                        logic [DW-1:0] pcv, tgv;
                        pcv = (p == 3) ? 32'hFFFF_FFFF : 32'h0000_1000 + DW'(c * 16 + f);
                        tgv = (p == 2) ? 32'hFFFF_FF00 : 32'h0004_0000 + DW'(p);
                        opa_in = av[p]; opb_in = bv[p];
                        idxa_in = sv[p] ? 5'd7 : 5'd3;
                        idxb_in = 5'd7;
                        cond_in = 6'(c); flags_in = 4'(f); rel_in = r[0];
                        pc_in = pcv; target_in = tgv;
                        start_in = 1'b1;
                        et  = exp_take(av[p], bv[p], sv[p], 6'(c), 4'(f));
                        epc = et ? (r[0] ? tgv + pcv : tgv) : pcv + DW'(1);
                        @(negedge clk);
                        start_in = 1'b0;
                        check("R8 valid pulse", DW'(valid_out), DW'(1));
                        if (sv[p] && c == 0)
                            check("R2 same-index equal", DW'(taken_out), DW'(1));
                        else if (c[5:4] == 2'd0)
                            check("R1 compare", DW'(taken_out), DW'(et));
                        else if (c[3:2] != 2'd0)
                            check("R3 flag select", DW'(taken_out), DW'(et));
                        else
                            check("R4 mix rule", DW'(taken_out), DW'(et));
                        if (!et)     check("R7 fall-through", next_pc_out, epc);
                        else if (r)  check("R6 relative", next_pc_out, epc);
                        else         check("R5 absolute", next_pc_out, epc);
                        if (f == 15 && r == 1) begin
                            opa_in = ~opa_in; target_in = ~target_in; pc_in = 32'h0;
                            @(negedge clk);
                            check("R8 no valid", DW'(valid_out), '0);
                            check("R8 hold taken", DW'(taken_out), DW'(et));
                            check("R8 hold pc", next_pc_out, epc);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule